// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block models one cell of a programmable logic array. A static configuration word sets up the cell. Five product-term values arrive already computed by the AND plane. The cell steers them into an OR sum that also takes in a cascade sum from a neighbouring cell. An XOR stage then sets the polarity. A storage element can run as a D, T, JK or SR flip-flop or as a transparent latch. The cell then chooses what drives the pin, the pin enable and the buried feedback. It also produces an inverted foldback term and passes its OR sum on as a cascade output, so eight chained cells reach a fan-in of 40 product terms.

The storage element runs on the system clock `sys_clk`. The cell clock is a level that the cell selects: either the global clock pin or a product term. Its rising edge is found by comparing it with its value one system cycle earlier. A rising edge, the open phase of the latch, and any clear or preset all take effect at the next `sys_clk` edge. Clear and preset still need no cell-clock edge. The cell has no streaming data path, so every pin is a plain level with no valid/ready handshake. The configuration word is captured only while `rst_n` is low.

Top module: `mc_cell`

## Requirements
- R1: Each bit of `sum_mask` that is 1 adds the product term at the same index to the OR sum. Terms whose mask bit is 0 have no effect on it. `cas_in` is ORed into the sum, and `cas_out` equals the full sum.
- R2: The XOR output is the OR sum XOR a second operand chosen by `xor_b`: 0 gives constant 0, 1 gives constant 1, 2 gives the term at `xor_pt`.
- R3: `fold` is the inverse of the product term chosen by `fold_pt`.
- R4: `pin_oe` follows `en_src`: 0 gives always 1, 1 gives always 0, 2 gives the inverse of `oe1_n`, 3 gives the inverse of `oe2_n`, 4 gives the term at `en_pt`.
- R5: With `out_reg`=1 both `pin_data` and `fb` show the stored bit. With `out_reg`=0, `pin_data` is the XOR output. `fb` is then the stored bit when `d_from_term`=1, which makes the data input the term at `d_pt`; otherwise `fb` is the XOR output.
- R6: With `kind`=0 (D), a rising cell-clock edge loads the data input, visible one `sys_clk` edge later. Without an edge the bit holds.
- R7: With `kind`=1 (T), a rising edge inverts the stored bit when the data input is 1 and holds it when the data input is 0.
- R8: With `kind`=2 (JK), the data input acts as J and the term at `aux_pt` acts as K. On an edge: 1/0 sets, 0/1 clears, 1/1 inverts, 0/0 holds.
- R9: With `kind`=3 (SR), the data input acts as S and the term at `aux_pt` acts as R. On an edge: S alone sets, R alone clears, both together clear, neither holds.
- R10: With `kind`=4 (latch), the bit follows the data input while the cell clock is high and holds while it is low.
- R11: `clk_from_term`=0 selects `gclk` as the cell clock; 1 selects the term at `clk_pt`. With `gclk` selected and `ce_on`=1, edges are ignored while the term at `ce_pt` is 0. With a term clock, `ce_on` has no effect.
- R12: Clear is active according to `clr_src`: 0 never, 1 when `gclr_n`=0, 2 when the term at `clr_pt` is 1, 3 when either holds. Preset is active when `pre_on`=1 and the term at `pre_pt` is 1. Both act one `sys_clk` edge later with no cell-clock edge. Clear wins over preset.
- R13: While `rst_n`=0 the stored bit is 0 and `cfg_word` is captured. After reset, changes on `cfg_word` have no effect. The layout of `cfg_word` is the packed `cell_cfg_t` of `mc_pkg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that samples the cell |
| rst_n | input | 1 | Active-low reset; captures the configuration |
| cfg_word | input | CFG_W | Packed cell configuration |
| pterm | input | N_PT | Product-term values |
| cas_in | input | 1 | Cascade sum from the neighbour |
| gclk | input | 1 | Global cell clock pin |
| gclr_n | input | 1 | Global clear pin, active low |
| oe1_n | input | 1 | Output-enable pin 1, active low |
| oe2_n | input | 1 | Output-enable pin 2, active low |
| pin_data | output | 1 | Data driven towards the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Buried feedback |
| fold | output | 1 | Inverted foldback term |
| cas_out | output | 1 | Cascade sum to the next cell |

## Verification
The combining path is driven from a table of four configurations. Each uses a different sum mask, XOR operand, enable source and foldback index. Terms are set both inside and outside the mask, which separates masked from unmasked terms and the cascade input from the local sum. Each storage kind is then run through edge sequences that reach every J/K and S/R combination. The sequences distinguish edge-loaded, toggling and transparent behaviour. Directed cases pit clear against preset, a gated clock against a term clock, the two feedback choices behind a combinational output, and a configuration change after reset.

// File: rtl/mc_pkg.sv
package mc_pkg;
  parameter int unsigned N_PT = 5;
  localparam int unsigned PT_IW = $clog2(N_PT);

  typedef logic [PT_IW-1:0] pt_idx_t;

  typedef enum logic [1:0] {XB_ZERO = 2'd0, XB_ONE = 2'd1, XB_TERM = 2'd2} xor_b_e;
  typedef enum logic [2:0] {RK_D = 3'd0, RK_T = 3'd1, RK_JK = 3'd2, RK_SR = 3'd3,
                            RK_LATCH = 3'd4} reg_kind_e;
  typedef enum logic [1:0] {CLR_NONE = 2'd0, CLR_PIN = 2'd1, CLR_TERM = 2'd2,
                            CLR_BOTH = 2'd3} clr_src_e;
  typedef enum logic [2:0] {EN_ON = 3'd0, EN_OFF = 3'd1, EN_PIN1 = 3'd2, EN_PIN2 = 3'd3,
                            EN_TERM = 3'd4} en_src_e;

  typedef struct packed {
    logic [N_PT-1:0] sum_mask;
    xor_b_e          xor_b;
    pt_idx_t         xor_pt;
    logic            d_from_term;
    pt_idx_t         d_pt;
    reg_kind_e       kind;
    pt_idx_t         aux_pt;
    logic            clk_from_term;
    pt_idx_t         clk_pt;
    logic            ce_on;
    pt_idx_t         ce_pt;
    clr_src_e        clr_src;
    pt_idx_t         clr_pt;
    logic            pre_on;
    pt_idx_t         pre_pt;
    logic            out_reg;
    en_src_e         en_src;
    pt_idx_t         en_pt;
    pt_idx_t         fold_pt;
  } cell_cfg_t;

  localparam int unsigned CFG_W = $bits(cell_cfg_t);

  // Index past the last term reads as 0.
  function automatic logic pick(input logic [N_PT-1:0] v, input pt_idx_t idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N_PT; i++) begin
      if (idx == pt_idx_t'(i)) r = v[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/mc_comb.sv
module mc_comb
  import mc_pkg::*;
(
  input  cell_cfg_t       cfg,
  input  logic [N_PT-1:0] pterm,
  input  logic            cas_in,
  output logic            xo,
  output logic            cas_out,
  output logic            fold,
  output logic            d_in,
  output logic            aux_t,
  output logic            clk_t,
  output logic            ce_t,
  output logic            clr_t,
  output logic            pre_t,
  output logic            en_t
);
  logic [N_PT-1:0] steered;
  logic            sum_all;
  logic            xb;

  for (genvar g = 0; g < N_PT; g++) begin : g_steer
    assign steered[g] = pterm[g] & cfg.sum_mask[g];
  end

  assign sum_all = (|steered) | cas_in;
  assign cas_out = sum_all;

  always_comb begin
    unique case (cfg.xor_b)
      XB_ONE:  xb = 1'b1;
      XB_TERM: xb = pick(pterm, cfg.xor_pt);
      default: xb = 1'b0;
    endcase
  end

  assign xo    = sum_all ^ xb;
  assign fold  = ~pick(pterm, cfg.fold_pt);
  assign d_in  = cfg.d_from_term ? pick(pterm, cfg.d_pt) : xo;
  assign aux_t = pick(pterm, cfg.aux_pt);
  assign clk_t = pick(pterm, cfg.clk_pt);
  assign ce_t  = pick(pterm, cfg.ce_pt);
  assign clr_t = pick(pterm, cfg.clr_pt);
  assign pre_t = pick(pterm, cfg.pre_pt);
  assign en_t  = pick(pterm, cfg.en_pt);
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic      sys_clk,
  input  logic      rst_n,
  input  reg_kind_e kind,
  input  logic      clk_from_term,
  input  logic      gclk,
  input  logic      clk_t,
  input  logic      ce_on,
  input  logic      ce_t,
  input  clr_src_e  clr_src,
  input  logic      gclr_n,
  input  logic      clr_t,
  input  logic      pre_on,
  input  logic      pre_t,
  input  logic      d_in,
  input  logic      aux_t,
  output logic      q
);
  logic ck, ck_prev, ce_ok, upd, clr, pre, nxt;

  assign ck    = clk_from_term ? clk_t : gclk;
  assign ce_ok = clk_from_term | ~ce_on | ce_t;
  assign upd   = ce_ok & ((kind == RK_LATCH) ? ck : (ck & ~ck_prev));

  always_comb begin
    unique case (clr_src)
      CLR_PIN:  clr = ~gclr_n;
      CLR_TERM: clr = clr_t;
      CLR_BOTH: clr = ~gclr_n | clr_t;
      default:  clr = 1'b0;
    endcase
  end
  assign pre = pre_on & pre_t;

  always_comb begin
    unique case (kind)
      RK_T:    nxt = q ^ d_in;
      RK_JK:   nxt = (d_in & ~q) | (~aux_t & q);
      RK_SR:   nxt = ~aux_t & (d_in | q);
      default: nxt = d_in;
    endcase
  end

  always_ff @(posedge sys_clk) begin
    if (!rst_n) begin
      q       <= 1'b0;
      ck_prev <= ck;
    end else begin
      ck_prev <= ck;
      if (clr)      q <= 1'b0;
      else if (pre) q <= 1'b1;
      else if (upd) q <= nxt;
    end
  end

  // R12
  clear_wins_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    clr |=> !q);
  // R12
  preset_sets_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (pre && !clr) |=> q);
  // R11
  ce_blocks_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!clk_from_term && ce_on && !ce_t && !clr && !pre) |=> $stable(q));
  // R7
  toggle_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (kind == RK_T && upd && d_in && !clr && !pre) |=> (q != $past(q)));
endmodule

// File: rtl/mc_io.sv
module mc_io
  import mc_pkg::*;
(
  input  logic    out_reg,
  input  logic    d_from_term,
  input  en_src_e en_src,
  input  logic    q,
  input  logic    xo,
  input  logic    en_t,
  input  logic    oe1_n,
  input  logic    oe2_n,
  output logic    pin_data,
  output logic    pin_oe,
  output logic    fb
);
  assign pin_data = out_reg ? q : xo;
  assign fb       = (out_reg | d_from_term) ? q : xo;

  always_comb begin
    unique case (en_src)
      EN_OFF:  pin_oe = 1'b0;
      EN_PIN1: pin_oe = ~oe1_n;
      EN_PIN2: pin_oe = ~oe2_n;
      EN_TERM: pin_oe = en_t;
      default: pin_oe = 1'b1;
    endcase
  end
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
(
  input  logic             sys_clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [N_PT-1:0]  pterm,
  input  logic             cas_in,
  input  logic             gclk,
  input  logic             gclr_n,
  input  logic             oe1_n,
  input  logic             oe2_n,
  output logic             pin_data,
  output logic             pin_oe,
  output logic             fb,
  output logic             fold,
  output logic             cas_out
);
  cell_cfg_t cfg_q;
  logic xo, d_in, aux_t, clk_t, ce_t, clr_t, pre_t, en_t, q;

  always_ff @(posedge sys_clk) begin
    if (!rst_n) cfg_q <= cell_cfg_t'(cfg_word);
  end

  mc_comb u_comb (
    .cfg(cfg_q), .pterm(pterm), .cas_in(cas_in), .xo(xo), .cas_out(cas_out),
    .fold(fold), .d_in(d_in), .aux_t(aux_t), .clk_t(clk_t), .ce_t(ce_t),
    .clr_t(clr_t), .pre_t(pre_t), .en_t(en_t)
  );

  mc_store u_store (
    .sys_clk(sys_clk), .rst_n(rst_n), .kind(cfg_q.kind),
    .clk_from_term(cfg_q.clk_from_term), .gclk(gclk), .clk_t(clk_t),
    .ce_on(cfg_q.ce_on), .ce_t(ce_t), .clr_src(cfg_q.clr_src), .gclr_n(gclr_n),
    .clr_t(clr_t), .pre_on(cfg_q.pre_on), .pre_t(pre_t), .d_in(d_in),
    .aux_t(aux_t), .q(q)
  );

  mc_io u_io (
    .out_reg(cfg_q.out_reg), .d_from_term(cfg_q.d_from_term), .en_src(cfg_q.en_src),
    .q(q), .xo(xo), .en_t(en_t), .oe1_n(oe1_n), .oe2_n(oe2_n),
    .pin_data(pin_data), .pin_oe(pin_oe), .fb(fb)
  );

  // R1
  cas_pass_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cas_in |-> cas_out);
  // R4
  oe_off_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (cfg_q.en_src == EN_OFF) |-> !pin_oe);
  // R13
  cfg_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg_q));
endmodule

// File: tb/sim_mc_cell.sv
module sim_mc_cell;
  import mc_pkg::*;

  logic sys_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CFG_W-1:0] cfg_word = '0;
  logic [N_PT-1:0] pterm = '0;
  logic cas_in = 1'b0, gclk = 1'b0, gclr_n = 1'b1, oe1_n = 1'b1, oe2_n = 1'b1;
  logic pin_data, pin_oe, fb, fold, cas_out;
  int checks = 0;
  int fails = 0;

  always #4 sys_clk = ~sys_clk;

  mc_cell u0 (
    .sys_clk(sys_clk), .rst_n(rst_n), .cfg_word(cfg_word), .pterm(pterm),
    .cas_in(cas_in), .gclk(gclk), .gclr_n(gclr_n), .oe1_n(oe1_n), .oe2_n(oe2_n),
    .pin_data(pin_data), .pin_oe(pin_oe), .fb(fb), .fold(fold), .cas_out(cas_out)
  );

  // [13:12] preset, [11:7] terms, [6] cas_in, [5] oe1_n, [4] oe2_n,
  // [3] pin_data, [2] pin_oe, [1] cas_out, [0] fold
  localparam logic [13:0] VECS [13] = '{
    14'b00_00000_0_11_0101, 14'b00_00100_0_11_1111, 14'b00_11000_0_11_0100,
    14'b00_00000_1_11_1111, 14'b01_00000_0_01_1101, 14'b01_00001_0_10_0010,
    14'b01_11100_0_01_1101, 14'b10_00001_0_11_1011, 14'b10_10001_0_11_0010,
    14'b10_11000_0_11_1100, 14'b11_10000_0_01_1011, 14'b11_00010_0_10_1110,
    14'b11_00000_0_10_0101
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge sys_clk);
    #1;
  endtask

  task automatic pulse;
    gclk = 1'b1; tick;
    gclk = 1'b0; tick;
  endtask

  task automatic load(input cell_cfg_t c);
    cfg_word = c; pterm = '0; cas_in = 0; gclk = 0; gclr_n = 1; oe1_n = 1; oe2_n = 1;
    rst_n = 0; tick; tick;
    rst_n = 1; tick;
  endtask

  function automatic cell_cfg_t table_cfg(input logic [1:0] id);
    cell_cfg_t c = '0;
    case (id)
      2'd0: begin c.sum_mask = 5'b00111; c.en_src = EN_ON; c.fold_pt = 3; end
      2'd1: begin c.sum_mask = 5'b00011; c.xor_b = XB_ONE; c.en_src = EN_PIN1; c.fold_pt = 0; end
      2'd2: begin c.sum_mask = 5'b00001; c.xor_b = XB_TERM; c.xor_pt = 4;
                  c.en_src = EN_TERM; c.en_pt = 3; c.fold_pt = 4; end
      default: begin c.sum_mask = 5'b11111; c.en_src = EN_PIN2; c.fold_pt = 1; end
    endcase
    return c;
  endfunction

  function automatic cell_cfg_t reg_cfg(input reg_kind_e k);
    cell_cfg_t c = '0;
    c.sum_mask = 5'b00001; c.kind = k; c.aux_pt = 1; c.out_reg = 1'b1;
    return c;
  endfunction

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cell_cfg_t c;

    // R13 reset state
    load(reg_cfg(RK_D));
    chk("R13 reset pin_data", pin_data, 1'b0);
    chk("R13 reset fb", fb, 1'b0);

    // R1 R2 R3 R4 table walk
    for (int i = 0; i < 13; i++) begin
      load(table_cfg(VECS[i][13:12]));
      pterm = VECS[i][11:7]; cas_in = VECS[i][6]; oe1_n = VECS[i][5]; oe2_n = VECS[i][4];
      #1;
      chk("R1/R2 pin_data", pin_data, VECS[i][3]);
      chk("R4 pin_oe", pin_oe, VECS[i][2]);
      chk("R1 cas_out", cas_out, VECS[i][1]);
      chk("R3 fold", fold, VECS[i][0]);
    end

    // R4 always off overrides the pins
    c = table_cfg(2'd0); c.en_src = EN_OFF; load(c);
    oe1_n = 0; oe2_n = 0; #1;
    chk("R4 off", pin_oe, 1'b0);

    // R6 D kind
    load(reg_cfg(RK_D));
    pterm = 5'b00001; tick;
    chk("R6 no edge holds", pin_data, 1'b0);
    pulse; chk("R6 load 1", pin_data, 1'b1);
    pterm = 5'b00000; pulse; chk("R6 load 0", fb, 1'b0);

    // R7 T kind
    load(reg_cfg(RK_T));
    pterm = 5'b00001; pulse; chk("R7 toggle up", pin_data, 1'b1);
    pulse; chk("R7 toggle down", pin_data, 1'b0);
    pterm = 5'b00000; pulse; chk("R7 hold", pin_data, 1'b0);

    // R8 JK kind: J = term0, K = term1
    load(reg_cfg(RK_JK));
    pterm = 5'b00001; pulse; chk("R8 J set", pin_data, 1'b1);
    pterm = 5'b00011; pulse; chk("R8 JK toggle 1", pin_data, 1'b0);
    pulse; chk("R8 JK toggle 2", pin_data, 1'b1);
    pterm = 5'b00000; pulse; chk("R8 hold", pin_data, 1'b1);
    pterm = 5'b00010; pulse; chk("R8 K clear", pin_data, 1'b0);

    // R9 SR kind: S = term0, R = term1
    load(reg_cfg(RK_SR));
    pterm = 5'b00001; pulse; chk("R9 set", pin_data, 1'b1);
    pterm = 5'b00000; pulse; chk("R9 hold", pin_data, 1'b1);
    pterm = 5'b00010; pulse; chk("R9 reset", pin_data, 1'b0);
    pterm = 5'b00001; pulse;
    pterm = 5'b00011; pulse; chk("R9 both clear", pin_data, 1'b0);

    // R10 latch kind
    load(reg_cfg(RK_LATCH));
    gclk = 1; pterm = 5'b00001; tick; chk("R10 open follows 1", pin_data, 1'b1);
    pterm = 5'b00000; tick; chk("R10 open follows 0", pin_data, 1'b0);
    gclk = 0; tick; pterm = 5'b00001; tick; tick;
    chk("R10 closed holds", pin_data, 1'b0);

    // R11 clock enable on global clock
    c = reg_cfg(RK_D); c.ce_on = 1; c.ce_pt = 2; load(c);
    pterm = 5'b00001; pulse; chk("R11 enable low ignores edge", pin_data, 1'b0);
    pterm = 5'b00101; pulse; chk("R11 enable high loads", pin_data, 1'b1);

    // R11 term clock, enable has no effect, global pin unused
    c = reg_cfg(RK_D); c.clk_from_term = 1; c.clk_pt = 3; c.ce_on = 1; c.ce_pt = 2; load(c);
    pterm = 5'b00001; pulse; chk("R11 gclk unused", pin_data, 1'b0);
    pterm = 5'b01001; tick; chk("R11 term clock loads", pin_data, 1'b1);

    // R12 pin clear without clock edge
    c = reg_cfg(RK_D); c.clr_src = CLR_PIN; load(c);
    pterm = 5'b00001; pulse;
    gclr_n = 0; tick; chk("R12 pin clear", pin_data, 1'b0);
    gclr_n = 1;

    // R12 preset, then clear against preset
    c = reg_cfg(RK_D); c.clr_src = CLR_TERM; c.clr_pt = 4; c.pre_on = 1; c.pre_pt = 3; load(c);
    pterm = 5'b01000; tick; chk("R12 preset", pin_data, 1'b1);
    pterm = 5'b11000; tick; chk("R12 clear wins", pin_data, 1'b0);
    pterm = 5'b00000; tick; chk("R12 hold after", pin_data, 1'b0);

    // R5 separate term data behind a combinational output
    c = reg_cfg(RK_D); c.out_reg = 0; c.d_from_term = 1; c.d_pt = 2; load(c);
    pterm = 5'b00001; #1;
    chk("R5 comb pin", pin_data, 1'b1);
    chk("R5 buried fb", fb, 1'b0);
    pterm = 5'b00100; pulse;
    chk("R5 buried fb loaded", fb, 1'b1);
    chk("R5 comb pin low", pin_data, 1'b0);
    c = reg_cfg(RK_D); c.out_reg = 0; load(c);
    pterm = 5'b00001; #1; chk("R5 comb fb", fb, 1'b1);

    // R13 config change after reset has no effect
    load(table_cfg(2'd0));
    c = table_cfg(2'd0); c.sum_mask = '0; c.xor_b = XB_ONE; c.en_src = EN_OFF;
    cfg_word = c; pterm = 5'b00001; tick;
    chk("R13 cfg held data", pin_data, 1'b1);
    chk("R13 cfg held oe", pin_oe, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule